// File: doc/BRIEF.md
# Quad-Pumped Inverting Data Path

This block models one agent's data path on a shared, 64-bit, active-low data bus that carries four words in every common clock. The block runs on the sub-phase clock, and a free-running two-bit sub-phase index stands in for the source-synchronous strobes. Four ticks of this index make one common clock. The transmit side accepts a 256-bit payload at the last sub-phase of a common clock. It then drives that payload as four 64-bit words during the next common clock, lowest word first. While the words are on the bus it holds the data-ready and bus-busy handshakes asserted.

Every word is split into four 16-bit lanes. Each lane carries its own active-low inversion flag, and each lane decides on its own, in each sub-phase, whether to invert. The rule is to invert whenever normal driving would pull more than half of the lane's wires low. This caps the number of low wires per lane at eight. The receive side samples each sub-phase that is marked by data-ready. It undoes the inversion lane by lane, stores the word in the slot named by the sub-phase index, and presents the rebuilt payload for one cycle after the last slot is filled.

Top module: `qdb_datapath`

## Requirements
- R1: After reset, the bus is released: every wire of `bus_d_n` and `bus_inv_n` is 1, `bus_drdy_n` = 1, `bus_dbsy_n` = 1 and `rx_valid` = 0. While `bus_drdy_n` is 1, the data and flag wires stay all ones.
- R2: `tx_ready` is 1 exactly when `bus_phase` = 3. A payload is taken on a clock edge where both `tx_valid` and `tx_ready` are 1. A `tx_valid` at any other sub-phase has no effect on the bus.
- R3: In the four cycles that follow acceptance, `bus_phase` reads 0, 1, 2, 3 and the bus carries payload bits [63:0], [127:64], [191:128] and [255:192] in that order, with `bus_drdy_n` = 0 and `bus_dbsy_n` = 0.
- R4: Lane g is bits [16g+15:16g] of the word, and its flag is `bus_inv_n[g]`. If the lane's data holds more than 8 ones, the lane is driven inverted: the wires equal the data bits and the flag is 0. Otherwise the wires are the complement of the data and the flag is 1. A lane with exactly 8 ones is not inverted.
- R5: While `bus_drdy_n` = 0, no lane of `bus_d_n` has more than 8 wires at 0.
- R6: If no new payload is accepted at the last sub-phase of a transfer, the bus returns to the released state of R1 in the next cycle.
- R7: A payload accepted during the last sub-phase of a transfer follows it at once, and `bus_dbsy_n` stays 0 across the boundary.
- R8: On each clock edge with `rx_drdy_n` = 0, each receive lane is decoded on its own: if `rx_inv_n[g]` = 0 the data is the wires as they are, otherwise it is their complement. The decoded word is stored in payload slot `rx_phase`, which is bits [64·rx_phase+63:64·rx_phase].
- R9: `rx_valid` is 1 for exactly the one cycle after an edge where `rx_drdy_n` = 0 and `rx_phase` = 3, and in that cycle `rx_payload` holds the four stored slots. Samples taken while `rx_drdy_n` = 1 change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-phase clock, four ticks per common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Payload offered for sending |
| tx_payload | input | 256 | Payload to send |
| tx_ready | output | 1 | Payload is taken on this edge if offered |
| bus_d_n | output | 64 | Driven data wires, active low |
| bus_inv_n | output | 4 | Per-lane inversion flags, active low |
| bus_drdy_n | output | 1 | Data-ready, active low |
| bus_dbsy_n | output | 1 | Bus-busy, active low |
| bus_phase | output | 2 | Sub-phase index (strobe model) |
| rx_d_n | input | 64 | Sampled data wires |
| rx_inv_n | input | 4 | Sampled inversion flags |
| rx_drdy_n | input | 1 | Sampled data-ready |
| rx_phase | input | 2 | Sampled sub-phase index |
| rx_valid | output | 1 | Rebuilt payload is valid this cycle |
| rx_payload | output | 256 | Rebuilt payload |

## Verification
The assertions are checked on every cycle. They cover the per-lane cap of eight low wires, the quiet bus while data-ready is idle, the strict 0-1-2-3 order of sub-phases under data-ready, busy covering ready, release or back-to-back continuation at the end of a transfer, and the one-cycle receive pulse. Only the bench's scenarios can show that each word holds the right payload slice with the right inversion choice, including the exact-eight and nine-ones lanes. The same holds for the loopback recovering random, all-zero and all-one payloads bit for bit, for the receiver honouring mixed flags it did not produce, and for idle-phase requests and idle-phase samples leaving no trace.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

    // Transmit ownership of the data bus
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_mode_e;

endpackage

// File: rtl/qdb_lane_enc.sv
module qdb_lane_enc #(
    parameter int GRP_W = 16
) (
    input  logic [GRP_W-1:0] data_i,
    output logic [GRP_W-1:0] wire_n_o,
    output logic             inv_n_o
);
    localparam int CNT_W = $clog2(GRP_W + 1);
    localparam int LIMIT = GRP_W / 2;

    logic [CNT_W-1:0] ones;

    // Logical ones become low wires when driven without inversion
    always_comb begin
        ones = '0;
        for (int i = 0; i < GRP_W; i++) begin
            ones = ones + CNT_W'(data_i[i]);
        end
    end

    // R4: invert only when more than half the wires would go low
    always_comb begin
        if (int'(ones) > LIMIT) begin
            wire_n_o = data_i;
            inv_n_o  = 1'b0;
        end else begin
            wire_n_o = ~data_i;
            inv_n_o  = 1'b1;
        end
    end

endmodule

// File: rtl/qdb_lane_dec.sv
module qdb_lane_dec #(
    parameter int GRP_W = 16
) (
    input  logic [GRP_W-1:0] wire_n_i,
    input  logic             inv_n_i,
    output logic [GRP_W-1:0] data_o
);
    // R8: an active flag means the wires already carry true polarity
    always_comb begin
        data_o = inv_n_i ? ~wire_n_i : wire_n_i;
    end

endmodule

// File: rtl/qdb_tx.sv
module qdb_tx
    import qdb_pkg::*;
#(
    parameter int BUS_W = 64,
    parameter int GRP_W = 16,
    parameter int SUBS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_valid,
    input  logic [BUS_W*SUBS-1:0] tx_payload,
    output logic                  tx_ready,
    output logic [BUS_W-1:0]      bus_d_n,
    output logic [BUS_W/GRP_W-1:0] bus_inv_n,
    output logic                  bus_drdy_n,
    output logic                  bus_dbsy_n,
    output logic [$clog2(SUBS)-1:0] bus_phase
);
    localparam int N_GRP = BUS_W / GRP_W;
    localparam int PH_W  = $clog2(SUBS);
    localparam int PAY_W = BUS_W * SUBS;
    localparam logic [PH_W-1:0] LAST = PH_W'(SUBS - 1);

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        tx_mode_e         mode;
        logic [PAY_W-1:0] payload;
        logic [BUS_W-1:0] d_n;
        logic [N_GRP-1:0] inv_n;
        logic             drdy_n;
        logic             dbsy_n;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic             accept;
    logic [PH_W-1:0]  nxt_ph;
    logic [BUS_W-1:0] src_word;
    logic [BUS_W-1:0] enc_d_n;
    logic [N_GRP-1:0] enc_inv_n;

    assign nxt_ph = st_q.phase + 1'b1;
    assign accept = tx_valid && (st_q.phase == LAST);

    // Word for the coming sub-phase: slot 0 of a new payload, or next stored slot
    always_comb begin
        if (accept) begin
            src_word = tx_payload[BUS_W-1:0];
        end else begin
            src_word = st_q.payload[int'(nxt_ph)*BUS_W +: BUS_W];
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_enc
        qdb_lane_enc #(.GRP_W(GRP_W)) u_enc (
            .data_i  (src_word[g*GRP_W +: GRP_W]),
            .wire_n_o(enc_d_n[g*GRP_W +: GRP_W]),
            .inv_n_o (enc_inv_n[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.phase = nxt_ph;
        if (accept) begin
            st_d.payload = tx_payload;
            st_d.mode    = TX_SEND;
            st_d.d_n     = enc_d_n;
            st_d.inv_n   = enc_inv_n;
            st_d.drdy_n  = 1'b0;
            st_d.dbsy_n  = 1'b0;
        end else if (st_q.mode == TX_SEND && st_q.phase != LAST) begin
            st_d.d_n     = enc_d_n;
            st_d.inv_n   = enc_inv_n;
            st_d.drdy_n  = 1'b0;
            st_d.dbsy_n  = 1'b0;
        end else if (st_q.phase == LAST) begin
            st_d.mode    = TX_IDLE;
            st_d.d_n     = '1;
            st_d.inv_n   = '1;
            st_d.drdy_n  = 1'b1;
            st_d.dbsy_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= '0;
            st_q.mode    <= TX_IDLE;
            st_q.payload <= '0;
            st_q.d_n     <= '1;
            st_q.inv_n   <= '1;
            st_q.drdy_n  <= 1'b1;
            st_q.dbsy_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready   = (st_q.phase == LAST);
    assign bus_d_n    = st_q.d_n;
    assign bus_inv_n  = st_q.inv_n;
    assign bus_drdy_n = st_q.drdy_n;
    assign bus_dbsy_n = st_q.dbsy_n;
    assign bus_phase  = st_q.phase;

    // Assertions
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drdy_n |-> (&bus_d_n && &bus_inv_n));

    p_ignore_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && bus_drdy_n) |=> bus_drdy_n);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!bus_drdy_n && bus_phase == '0));

    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_drdy_n && bus_phase != LAST) |=>
            (!bus_drdy_n && bus_phase == $past(bus_phase) + 1'b1));

    p_busy_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drdy_n |-> !bus_dbsy_n);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_drdy_n && bus_phase == LAST && !tx_valid) |=>
            (bus_drdy_n && bus_dbsy_n && &bus_d_n && &bus_inv_n));

    p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_drdy_n && bus_phase == LAST && tx_valid) |=>
            (!bus_dbsy_n && !bus_drdy_n && bus_phase == '0));

    for (genvar g = 0; g < N_GRP; g++) begin : g_lim
        p_low_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_drdy_n |-> ($countones(~bus_d_n[g*GRP_W +: GRP_W]) <= GRP_W/2));
    end

endmodule

// File: rtl/qdb_rx.sv
module qdb_rx #(
    parameter int BUS_W = 64,
    parameter int GRP_W = 16,
    parameter int SUBS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BUS_W-1:0]         rx_d_n,
    input  logic [BUS_W/GRP_W-1:0]   rx_inv_n,
    input  logic                     rx_drdy_n,
    input  logic [$clog2(SUBS)-1:0]  rx_phase,
    output logic                     rx_valid,
    output logic [BUS_W*SUBS-1:0]    rx_payload
);
    localparam int N_GRP = BUS_W / GRP_W;
    localparam int PH_W  = $clog2(SUBS);
    localparam int PAY_W = BUS_W * SUBS;
    localparam logic [PH_W-1:0] LAST = PH_W'(SUBS - 1);

    typedef struct packed {
        logic             valid;
        logic [PAY_W-1:0] slots;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [BUS_W-1:0] dec_word;

    for (genvar g = 0; g < N_GRP; g++) begin : g_dec
        qdb_lane_dec #(.GRP_W(GRP_W)) u_dec (
            .wire_n_i(rx_d_n[g*GRP_W +: GRP_W]),
            .inv_n_i (rx_inv_n[g]),
            .data_o  (dec_word[g*GRP_W +: GRP_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = !rx_drdy_n && (rx_phase == LAST);
        if (!rx_drdy_n) begin
            st_d.slots[int'(rx_phase)*BUS_W +: BUS_W] = dec_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.slots <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid   = st_q.valid;
    assign rx_payload = st_q.slots;

    // Assertions
    p_valid_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_drdy_n && rx_phase == LAST) |=> rx_valid);

    p_valid_only_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rx_drdy_n && rx_phase == LAST) |=> !rx_valid);

    p_idle_keeps_slots_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drdy_n |=> $stable(rx_payload));

endmodule

// File: rtl/qdb_datapath.sv
module qdb_datapath #(
    parameter int BUS_W = 64,
    parameter int GRP_W = 16,
    parameter int SUBS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_valid,
    input  logic [BUS_W*SUBS-1:0]    tx_payload,
    output logic                     tx_ready,
    output logic [BUS_W-1:0]         bus_d_n,
    output logic [BUS_W/GRP_W-1:0]   bus_inv_n,
    output logic                     bus_drdy_n,
    output logic                     bus_dbsy_n,
    output logic [$clog2(SUBS)-1:0]  bus_phase,
    input  logic [BUS_W-1:0]         rx_d_n,
    input  logic [BUS_W/GRP_W-1:0]   rx_inv_n,
    input  logic                     rx_drdy_n,
    input  logic [$clog2(SUBS)-1:0]  rx_phase,
    output logic                     rx_valid,
    output logic [BUS_W*SUBS-1:0]    rx_payload
);
    qdb_tx #(.BUS_W(BUS_W), .GRP_W(GRP_W), .SUBS(SUBS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_payload(tx_payload),
        .tx_ready  (tx_ready),
        .bus_d_n   (bus_d_n),
        .bus_inv_n (bus_inv_n),
        .bus_drdy_n(bus_drdy_n),
        .bus_dbsy_n(bus_dbsy_n),
        .bus_phase (bus_phase)
    );

    qdb_rx #(.BUS_W(BUS_W), .GRP_W(GRP_W), .SUBS(SUBS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_d_n    (rx_d_n),
        .rx_inv_n  (rx_inv_n),
        .rx_drdy_n (rx_drdy_n),
        .rx_phase  (rx_phase),
        .rx_valid  (rx_valid),
        .rx_payload(rx_payload)
    );

endmodule

// File: tb/qdb_datapath_test.sv
module qdb_datapath_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [255:0] tx_payload = '0;
    logic         tx_ready;
    logic [63:0]  bus_d_n;
    logic [3:0]   bus_inv_n;
    logic         bus_drdy_n, bus_dbsy_n;
    logic [1:0]   bus_phase;
    logic         rx_valid;
    logic [255:0] rx_payload;

    // Loopback or direct drive of the receive pins
    logic         lb = 1'b1;
    logic [63:0]  drv_d_n = '1;
    logic [3:0]   drv_inv_n = '1;
    logic         drv_drdy_n = 1'b1;
    logic [1:0]   drv_phase = '0;
    logic [63:0]  rx_d_n;
    logic [3:0]   rx_inv_n;
    logic         rx_drdy_n;
    logic [1:0]   rx_phase;

    assign rx_d_n    = lb ? bus_d_n    : drv_d_n;
    assign rx_inv_n  = lb ? bus_inv_n  : drv_inv_n;
    assign rx_drdy_n = lb ? bus_drdy_n : drv_drdy_n;
    assign rx_phase  = lb ? bus_phase  : drv_phase;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    qdb_datapath uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_payload(tx_payload), .tx_ready(tx_ready),
        .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n), .bus_drdy_n(bus_drdy_n),
        .bus_dbsy_n(bus_dbsy_n), .bus_phase(bus_phase),
        .rx_d_n(rx_d_n), .rx_inv_n(rx_inv_n), .rx_drdy_n(rx_drdy_n),
        .rx_phase(rx_phase), .rx_valid(rx_valid), .rx_payload(rx_payload)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Lane encoding rule from R4: returns {flag, wires}
    function automatic logic [16:0] exp_lane(input logic [15:0] d);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(d[i]);
        if (n > 8) return {1'b0, d};
        return {1'b1, ~d};
    endfunction

    function automatic int zeros16(input logic [15:0] w);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(!w[i]);
        return n;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check_idle(input string req);
        chk(bus_drdy_n === 1'b1 && bus_dbsy_n === 1'b1, req, "handshakes released",
            {bus_drdy_n, bus_dbsy_n}, 2'b11);
        chk(bus_d_n === '1 && bus_inv_n === '1, req, "data and flags all ones",
            {bus_inv_n, bus_d_n}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    // Checks one driven word against R3, R4 and R5
    task automatic check_word(input logic [255:0] pay, input int k);
        logic [63:0] w, exp_w;
        logic [3:0]  exp_f;
        logic [16:0] e;
        w = pay[k*64 +: 64];
        for (int g = 0; g < 4; g++) begin
            e = exp_lane(w[g*16 +: 16]);
            exp_w[g*16 +: 16] = e[15:0];
            exp_f[g] = e[16];
        end
        chk(bus_phase === 2'(k) && bus_drdy_n === 1'b0 && bus_dbsy_n === 1'b0,
            "R3", "phase and handshakes", {bus_phase, bus_drdy_n, bus_dbsy_n},
            {2'(k), 2'b00});
        chk(bus_d_n === exp_w, "R4", "lane wires", bus_d_n, exp_w);
        chk(bus_inv_n === exp_f, "R4", "lane flags", bus_inv_n, exp_f);
        for (int g = 0; g < 4; g++) begin
            chk(zeros16(bus_d_n[g*16 +: 16]) <= 8, "R5", "low wires per lane",
                zeros16(bus_d_n[g*16 +: 16]), 8);
        end
    endtask

    task automatic wait_ready();
        while (tx_ready !== 1'b1) @(negedge clk);
    endtask

    task automatic t_reset();
        check_idle("R1");
        chk(rx_valid === 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    endtask

    // Single transfer in loopback: R2, R3, R4, R5, R6, R9
    task automatic t_send(input logic [255:0] pay);
        wait_ready();
        chk(bus_phase === 2'd3, "R2", "ready only in last sub-phase", bus_phase, 3);
        tx_valid = 1'b1;
        tx_payload = pay;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_word(pay, k);
            @(negedge clk);
        end
        chk(rx_valid === 1'b1, "R9", "valid after last slot", rx_valid, 1);
        chk(rx_payload === pay, "R9", "payload recovered", rx_payload, pay);
        check_idle("R6");
        @(negedge clk);
        chk(rx_valid === 1'b0, "R9", "valid is a single pulse", rx_valid, 0);
    endtask

    // Back-to-back transfers: R7
    task automatic t_b2b(input logic [255:0] p1, input logic [255:0] p2);
        wait_ready();
        tx_valid = 1'b1;
        tx_payload = p1;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_word(p1, k);
            if (k == 3) begin
                chk(tx_ready === 1'b1, "R7", "ready in last word", tx_ready, 1);
                tx_valid = 1'b1;
                tx_payload = p2;
            end
            @(negedge clk);
        end
        tx_valid = 1'b0;
        chk(rx_valid === 1'b1 && rx_payload === p1, "R7", "first payload recovered",
            rx_payload, p1);
        chk(bus_dbsy_n === 1'b0, "R7", "busy held across boundary", bus_dbsy_n, 0);
        for (int k = 0; k < 4; k++) begin
            check_word(p2, k);
            @(negedge clk);
        end
        chk(rx_valid === 1'b1 && rx_payload === p2, "R7", "second payload recovered",
            rx_payload, p2);
        check_idle("R6");
    endtask

    // Offer outside the last sub-phase, withdraw before it: R2
    task automatic t_ignore();
        while (bus_phase !== 2'd0) @(negedge clk);
        tx_valid = 1'b1;
        tx_payload = '1;
        chk(tx_ready === 1'b0, "R2", "ready low in sub-phase 0", tx_ready, 0);
        @(negedge clk);
        check_idle("R2");
        @(negedge clk);
        check_idle("R2");
        tx_valid = 1'b0;
        @(negedge clk);
        check_idle("R2");
        @(negedge clk);
        check_idle("R2");
    endtask

    // Direct drive of the receiver with mixed flags: R8, R9
    task automatic t_rx_direct();
        logic [63:0]  wv [4];
        logic [3:0]   fv [4];
        logic [255:0] exp_p;
        wv[0] = 64'hFFFF_0000_01FF_00FF; fv[0] = 4'b0101;
        wv[1] = 64'h1234_ABCD_0F0F_FFFF; fv[1] = 4'b0000;
        wv[2] = 64'hAAAA_5555_C3C3_8001; fv[2] = 4'b1111;
        wv[3] = 64'h0000_FFFF_7E7E_1111; fv[3] = 4'b1010;
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < 4; g++) begin
                exp_p[k*64 + g*16 +: 16] = fv[k][g] ? ~wv[k][g*16 +: 16]
                                                    : wv[k][g*16 +: 16];
            end
        end
        @(negedge clk);
        lb = 1'b0;
        drv_drdy_n = 1'b1; drv_phase = 2'd3; drv_d_n = 64'h0; drv_inv_n = 4'h0;
        @(negedge clk);
        chk(rx_valid === 1'b0, "R9", "idle last-phase sample ignored", rx_valid, 0);
        for (int k = 0; k < 4; k++) begin
            drv_drdy_n = 1'b0; drv_phase = 2'(k); drv_d_n = wv[k]; drv_inv_n = fv[k];
            @(negedge clk);
            if (k == 1) begin
                drv_drdy_n = 1'b1; drv_phase = 2'd1; drv_d_n = 64'h0; drv_inv_n = 4'h0;
                @(negedge clk);
            end
        end
        drv_drdy_n = 1'b1;
        chk(rx_valid === 1'b1, "R8", "valid after direct frame", rx_valid, 1);
        chk(rx_payload === exp_p, "R8", "per-lane decode with mixed flags",
            rx_payload, exp_p);
        lb = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] crafted;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        crafted = rnd256();
        crafted[63:0]   = {16'h0000, 16'hFFFF, 16'h01FF, 16'h00FF};
        crafted[127:64] = {16'h5555, 16'hAAAA, 16'h0001, 16'h7FFF};
        t_send(crafted);
        t_send('0);
        t_send('1);
        for (int i = 0; i < 6; i++) t_send(rnd256());
        t_ignore();
        t_b2b(rnd256(), crafted);
        t_rx_direct();
        t_send(rnd256());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule